// File: doc/BRIEF.md
# Out-of-Order Issue Window Scheduler

This block holds a small pool of decoded instructions and sends ready ones to execution without keeping program order. Instructions come in, one per cycle and in program order, through a valid/ready dispatch port. Each carries two source tags, each with an already-available flag, a destination tag and an operation class (ALU or divide). A result-tag broadcast port tells the pool that a value has been produced. Every waiting source that names that tag becomes ready.

Each cycle the block looks at the entries whose sources are all ready. It picks the oldest such entry for the single-cycle ALU and, separately, the oldest such entry for the divider. The divider stays occupied for a fixed latency after it accepts an operation. Independent ALU work keeps issuing in that time. A flush empties the pool in one cycle. Back-pressure: a dispatch is taken on a cycle where `disp_valid` and `disp_ready` are both high. `disp_ready` is low while every slot is occupied and during a flush. The producer must hold its request until it is taken. The issue outputs carry no ready signal, because the execution units always take what is offered.

Top module: `ooo_issue_sched`

## Requirements
- R1: A dispatch is accepted only when `disp_valid` and `disp_ready` are both high. `disp_ready` is low while all DEPTH (8) slots hold valid entries or `flush` is high.
- R2: An entry does not issue while one of its sources is not ready. `disp_srcN_rdy`=1 marks a source as already available, and a source an instruction does not use is dispatched with its flag at 1.
- R3: When `bcast_valid` is high with tag T, every waiting source holding T becomes ready at the next edge. The entry can then issue in the following cycle.
- R4: A source whose tag equals a broadcast tag in the cycle it is dispatched is stored as ready.
- R5: When several entries of one class are ready, the one dispatched earliest issues first. At most one ALU and one divide issue per cycle.
- R6: After a divide issues, no other divide issues for DIV_LAT (20) cycles. `div_busy` is high on the DIV_LAT-1 cycles after the issue cycle.
- R7: Ready ALU entries keep issuing while the divider is busy, including entries dispatched after a waiting divide.
- R8: `flush` removes all entries at the next edge, so nothing issues in the following cycle. A divide already issued still holds the divider for its full latency.
- R9: After reset, no issue output is valid, `div_busy` is 0 and `disp_ready` is 1.
- R10: An entry dispatched with all sources ready into an empty pool issues in the cycle after it is accepted. `disp_op`=0 selects the ALU and `disp_op`=1 selects the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard every held entry |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Pool can take a dispatch |
| disp_op | input | 1 | Operation class: 0 ALU, 1 divide |
| disp_src1_tag | input | TAG_W | First source tag |
| disp_src1_rdy | input | 1 | First source already available |
| disp_src2_tag | input | TAG_W | Second source tag |
| disp_src2_rdy | input | 1 | Second source already available |
| disp_dst_tag | input | TAG_W | Destination tag |
| bcast_valid | input | 1 | Result tag broadcast strobe |
| bcast_tag | input | TAG_W | Broadcast result tag |
| alu_issue_valid | output | 1 | An ALU entry issues this cycle |
| alu_issue_dst | output | TAG_W | Destination tag of the ALU issue |
| div_issue_valid | output | 1 | A divide entry issues this cycle |
| div_issue_dst | output | TAG_W | Destination tag of the divide issue |
| div_busy | output | 1 | Divider occupied by an earlier divide |

## Verification
Two pairs of functions can land on the same cycle. A broadcast can coincide with the dispatch of an instruction that waits on that very tag. A flush can coincide with an issue or a divide start. The random phase drives broadcast tags from the same four-bit space as the dispatched sources, and injects flushes at random. Both collisions therefore arise often, and directed steps pin each one down. Each cycle is judged by a bench model. The model keeps entries tagged with a running sequence number and applies issue, wakeup, dispatch and flush in the order the requirements give. Its expected issue tags, ready and busy flags are compared with the ports.

// File: rtl/ooo_sched_pkg.sv
package ooo_sched_pkg;
  typedef enum logic {
    OP_ALU = 1'b0,
    OP_DIV = 1'b1
  } op_class_e;

  localparam int unsigned NUM_UNITS = 2;
  localparam int unsigned UNIT_ALU  = 0;
  localparam int unsigned UNIT_DIV  = 1;
endpackage

// File: rtl/sched_age_matrix.sv
module sched_age_matrix #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         alloc_en,
  input  logic [IDX_W-1:0]             alloc_idx,
  output logic [DEPTH-1:0][DEPTH-1:0]  older
);
  // older[a][b] set: slot a was allocated before slot b
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      older <= '0;
    end else if (alloc_en) begin
      for (int a = 0; a < DEPTH; a++) begin
        for (int b = 0; b < DEPTH; b++) begin
          if (a == int'(alloc_idx)) older[a][b] <= 1'b0;
          else if (b == int'(alloc_idx)) older[a][b] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sched_oldest_pick.sv
module sched_oldest_pick #(
  parameter int unsigned DEPTH = 8
) (
  input  logic [DEPTH-1:0]             req,
  input  logic [DEPTH-1:0][DEPTH-1:0]  older,
  output logic [DEPTH-1:0]             gnt
);
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic beaten;
      beaten = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        if (j != i && req[j] && older[j][i]) beaten = 1'b1;
      end
      gnt[i] = req[i] & ~beaten;
    end
  end
endmodule

// File: rtl/sched_div_timer.sv
module sched_div_timer #(
  parameter int unsigned LAT = 20,
  localparam int unsigned CNT_W = (LAT > 2) ? $clog2(LAT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)              remain <= '0;
    else if (start)          remain <= CNT_W'(LAT - 1);
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);

  a_r6_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  a_r6_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy || (LAT <= 1)));
endmodule

// File: rtl/ooo_issue_sched.sv
module ooo_issue_sched
  import ooo_sched_pkg::*;
#(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned TAG_W   = 4,
  parameter int unsigned DIV_LAT = 20,
  localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             disp_valid,
  output logic             disp_ready,
  input  logic             disp_op,
  input  logic [TAG_W-1:0] disp_src1_tag,
  input  logic             disp_src1_rdy,
  input  logic [TAG_W-1:0] disp_src2_tag,
  input  logic             disp_src2_rdy,
  input  logic [TAG_W-1:0] disp_dst_tag,
  input  logic             bcast_valid,
  input  logic [TAG_W-1:0] bcast_tag,
  output logic             alu_issue_valid,
  output logic [TAG_W-1:0] alu_issue_dst,
  output logic             div_issue_valid,
  output logic [TAG_W-1:0] div_issue_dst,
  output logic             div_busy
);
  logic [DEPTH-1:0] slot_vld, slot_div, slot_r1, slot_r2;
  logic [TAG_W-1:0] slot_t1 [DEPTH];
  logic [TAG_W-1:0] slot_t2 [DEPTH];
  logic [TAG_W-1:0] slot_dst[DEPTH];

  logic                        accept;
  logic [IDX_W-1:0]            free_idx;
  logic [DEPTH-1:0][DEPTH-1:0] older;
  logic [DEPTH-1:0]            req_u [NUM_UNITS];
  logic [DEPTH-1:0]            gnt_u [NUM_UNITS];
  logic [DEPTH-1:0]            both_rdy, issued;
  logic                        in_r1, in_r2;

  assign disp_ready = ~(&slot_vld) & ~flush;
  assign accept     = disp_valid & disp_ready;

  // lowest free slot
  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!slot_vld[i]) free_idx = IDX_W'(i);
    end
  end

  assign in_r1 = disp_src1_rdy | (bcast_valid && disp_src1_tag == bcast_tag);
  assign in_r2 = disp_src2_rdy | (bcast_valid && disp_src2_tag == bcast_tag);

  sched_age_matrix #(.DEPTH(DEPTH)) u_age (
    .clk(clk), .rst_n(rst_n), .alloc_en(accept), .alloc_idx(free_idx), .older(older)
  );

  assign both_rdy        = slot_vld & slot_r1 & slot_r2;
  assign req_u[UNIT_ALU] = both_rdy & ~slot_div;
  assign req_u[UNIT_DIV] = both_rdy & slot_div & {DEPTH{~div_busy}};

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    sched_oldest_pick #(.DEPTH(DEPTH)) u_pick (
      .req(req_u[u]), .older(older), .gnt(gnt_u[u])
    );
  end

  assign issued = gnt_u[UNIT_ALU] | gnt_u[UNIT_DIV];

  always_comb begin
    alu_issue_dst = '0;
    div_issue_dst = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (gnt_u[UNIT_ALU][i]) alu_issue_dst = alu_issue_dst | slot_dst[i];
      if (gnt_u[UNIT_DIV][i]) div_issue_dst = div_issue_dst | slot_dst[i];
    end
  end
  assign alu_issue_valid = |gnt_u[UNIT_ALU];
  assign div_issue_valid = |gnt_u[UNIT_DIV];

  sched_div_timer #(.LAT(DIV_LAT)) u_div_timer (
    .clk(clk), .rst_n(rst_n), .start(div_issue_valid), .busy(div_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_vld <= '0;
      slot_div <= '0;
      slot_r1  <= '0;
      slot_r2  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        slot_t1[i]  <= '0;
        slot_t2[i]  <= '0;
        slot_dst[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (flush) begin
          slot_vld[i] <= 1'b0;
        end else if (accept && free_idx == IDX_W'(i)) begin
          slot_vld[i] <= 1'b1;
          slot_div[i] <= (disp_op == OP_DIV);
          slot_r1[i]  <= in_r1;
          slot_r2[i]  <= in_r2;
          slot_t1[i]  <= disp_src1_tag;
          slot_t2[i]  <= disp_src2_tag;
          slot_dst[i] <= disp_dst_tag;
        end else begin
          if (issued[i]) slot_vld[i] <= 1'b0;
          if (bcast_valid && slot_t1[i] == bcast_tag) slot_r1[i] <= 1'b1;
          if (bcast_valid && slot_t2[i] == bcast_tag) slot_r2[i] <= 1'b1;
        end
      end
    end
  end

  a_r5_single_alu_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_u[UNIT_ALU]));
  a_r5_single_div_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_u[UNIT_DIV]));
  a_r1_fill_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && $countones(slot_vld) == DEPTH - 1 && issued == '0) |=> !disp_ready);
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (slot_vld == '0 && !alu_issue_valid && !div_issue_valid));
  a_r10_fast_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && slot_vld == '0 && disp_op == OP_ALU && disp_src1_rdy && disp_src2_rdy)
      |=> alu_issue_valid);
endmodule

// File: tb/sim_ooo_issue_sched.sv
module sim_ooo_issue_sched;
  localparam int DEPTH = 8;
  localparam int LAT   = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0, disp_valid = 1'b0, disp_op = 1'b0;
  logic [3:0] disp_src1_tag = '0, disp_src2_tag = '0, disp_dst_tag = '0, bcast_tag = '0;
  logic disp_src1_rdy = 1'b0, disp_src2_rdy = 1'b0, bcast_valid = 1'b0;
  logic disp_ready, alu_issue_valid, div_issue_valid, div_busy;
  logic [3:0] alu_issue_dst, div_issue_dst;

  int checks = 0, fails = 0, nstep = 0;

  always #4 clk = ~clk;

  ooo_issue_sched u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_op(disp_op), .disp_src1_tag(disp_src1_tag), .disp_src1_rdy(disp_src1_rdy),
    .disp_src2_tag(disp_src2_tag), .disp_src2_rdy(disp_src2_rdy), .disp_dst_tag(disp_dst_tag),
    .bcast_valid(bcast_valid), .bcast_tag(bcast_tag), .alu_issue_valid(alu_issue_valid),
    .alu_issue_dst(alu_issue_dst), .div_issue_valid(div_issue_valid),
    .div_issue_dst(div_issue_dst), .div_busy(div_busy)
  );

  // bench model: entries ordered by a running sequence number
  bit m_v[DEPTH], m_div[DEPTH], m_r1[DEPTH], m_r2[DEPTH];
  int m_seq[DEPTH], m_t1[DEPTH], m_t2[DEPTH], m_dst[DEPTH];
  int m_cnt = 0, m_next = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s step=%0d actual=%0d expected=%0d", req, nstep, act, exp);
    end
  endtask

  function automatic int oldest_ready(input bit want_div);
    int best = -1;
    for (int i = 0; i < DEPTH; i++) begin
      if (m_v[i] && m_div[i] == want_div && m_r1[i] && m_r2[i])
        if (best < 0 || m_seq[i] < m_seq[best]) best = i;
    end
    return best;
  endfunction

  function automatic int held();
    int n = 0;
    for (int i = 0; i < DEPTH; i++) n += int'(m_v[i]);
    return n;
  endfunction

  task automatic settle_idle();
    disp_valid = 0; bcast_valid = 0; flush = 0;
    #1;
  endtask

  task automatic step(input bit dv, input bit op, input int t1, input bit r1, input int t2,
                      input bit r2, input int d, input bit bv, input int bt, input bit fl);
    int ia, id, slot;
    bit exp_rdy, acc;
    disp_valid = dv; disp_op = op; disp_src1_tag = 4'(t1); disp_src1_rdy = r1;
    disp_src2_tag = 4'(t2); disp_src2_rdy = r2; disp_dst_tag = 4'(d);
    bcast_valid = bv; bcast_tag = 4'(bt); flush = fl;
    #1;
    exp_rdy = (held() < DEPTH) && !fl;
    ia = oldest_ready(1'b0);
    id = (m_cnt == 0) ? oldest_ready(1'b1) : -1;
    chk(disp_ready == exp_rdy, "R1", int'(disp_ready), int'(exp_rdy));
    chk(alu_issue_valid == (ia >= 0), "R5", int'(alu_issue_valid), int'(ia >= 0));
    if (ia >= 0) chk(alu_issue_dst == 4'(m_dst[ia]), "R5", int'(alu_issue_dst), m_dst[ia]);
    chk(div_issue_valid == (id >= 0), "R6", int'(div_issue_valid), int'(id >= 0));
    if (id >= 0) chk(div_issue_dst == 4'(m_dst[id]), "R6", int'(div_issue_dst), m_dst[id]);
    chk(div_busy == (m_cnt != 0), "R6", int'(div_busy), int'(m_cnt != 0));
    // advance model
    acc = dv && exp_rdy;
    if (id >= 0) m_cnt = LAT - 1; else if (m_cnt > 0) m_cnt--;
    if (ia >= 0) m_v[ia] = 0;
    if (id >= 0) m_v[id] = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (bv && m_t1[i] == bt) m_r1[i] = 1;
      if (bv && m_t2[i] == bt) m_r2[i] = 1;
    end
    if (acc) begin
      slot = -1;
      for (int i = DEPTH - 1; i >= 0; i--) if (!m_v[i]) slot = i;
      m_v[slot] = 1; m_div[slot] = op; m_seq[slot] = m_next++;
      m_t1[slot] = t1; m_t2[slot] = t2; m_dst[slot] = d;
      m_r1[slot] = r1 || (bv && t1 == bt);
      m_r2[slot] = r2 || (bv && t2 == bt);
    end
    if (fl) for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
    @(posedge clk);
    @(negedge clk);
    nstep++;
    settle_idle();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 1, 0, 1, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int t7;
    bit seen;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R9 reset state
    chk(!alu_issue_valid && !div_issue_valid, "R9", int'(alu_issue_valid), 0);
    chk(!div_busy && disp_ready, "R9", int'(div_busy), 0);

    // R10 ready ALU entry issues next cycle
    step(1, 0, 0, 1, 0, 1, 3, 0, 0, 0);
    chk(alu_issue_valid && alu_issue_dst == 4'd3, "R10", int'(alu_issue_dst), 3);
    idle(1);

    // R2 then R3: wait on tag 6, broadcast it
    step(1, 0, 6, 0, 0, 1, 4, 0, 0, 0);
    chk(!alu_issue_valid, "R2", int'(alu_issue_valid), 0);
    step(0, 0, 0, 1, 0, 1, 0, 1, 6, 0);
    chk(alu_issue_valid && alu_issue_dst == 4'd4, "R3", int'(alu_issue_dst), 4);
    idle(1);

    // R4 broadcast in the dispatch cycle
    step(1, 0, 5, 0, 0, 1, 12, 1, 5, 0);
    chk(alu_issue_valid && alu_issue_dst == 4'd12, "R4", int'(alu_issue_dst), 12);
    idle(1);

    // R5 oldest-first among simultaneously woken entries
    step(1, 0, 9, 0, 0, 1, 1, 0, 0, 0);
    step(1, 0, 9, 0, 0, 1, 2, 0, 0, 0);
    step(1, 0, 0, 1, 9, 0, 3, 0, 0, 0);
    step(0, 0, 0, 1, 0, 1, 0, 1, 9, 0);
    chk(alu_issue_dst == 4'd1, "R5", int'(alu_issue_dst), 1);
    idle(1);
    chk(alu_issue_dst == 4'd2, "R5", int'(alu_issue_dst), 2);
    idle(1);
    chk(alu_issue_dst == 4'd3, "R5", int'(alu_issue_dst), 3);
    idle(2);

    // R6 / R7 divider occupancy and ALU bypass
    idle(LAT + 2);
    step(1, 1, 0, 1, 0, 1, 7, 0, 0, 0);
    chk(div_issue_valid && div_issue_dst == 4'd7, "R6", int'(div_issue_dst), 7);
    t7 = nstep;
    step(1, 1, 0, 1, 0, 1, 8, 0, 0, 0);
    chk(div_busy, "R6", int'(div_busy), 1);
    step(1, 0, 0, 1, 0, 1, 10, 0, 0, 0);
    chk(alu_issue_valid && alu_issue_dst == 4'd10 && !div_issue_valid, "R7",
        int'(alu_issue_dst), 10);
    seen = 0;
    for (int k = 0; k < LAT + 4 && !seen; k++) begin
      idle(1);
      if (div_issue_valid && div_issue_dst == 4'd8) begin
        seen = 1;
        chk(nstep - t7 == LAT, "R6", nstep - t7, LAT);
      end
    end
    chk(seen, "R6", int'(seen), 1);
    idle(1);

    // R8 flush drops waiting entries
    step(1, 0, 13, 0, 0, 1, 5, 0, 0, 0);
    step(1, 0, 13, 0, 0, 1, 6, 0, 0, 0);
    step(0, 0, 0, 1, 0, 1, 0, 0, 0, 1);
    chk(!alu_issue_valid && !div_issue_valid && disp_ready, "R8", int'(alu_issue_valid), 0);
    step(0, 0, 0, 1, 0, 1, 0, 1, 13, 0);
    chk(!alu_issue_valid, "R8", int'(alu_issue_valid), 0);

    // R1 full pool stalls dispatch
    for (int k = 0; k < DEPTH; k++) step(1, 0, 14, 0, 14, 0, k, 0, 0, 0);
    chk(!disp_ready, "R1", int'(disp_ready), 0);
    step(1, 0, 0, 1, 0, 1, 15, 0, 0, 0);
    chk(!alu_issue_valid, "R1", int'(alu_issue_valid), 0);
    step(0, 0, 0, 1, 0, 1, 0, 0, 0, 1);

    // constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 10) < 7, ($urandom % 5) == 0,
           int'($urandom % 16), ($urandom % 2) == 0,
           int'($urandom % 16), ($urandom % 2) == 0,
           int'($urandom % 16), ($urandom % 10) < 6, int'($urandom % 16),
           ($urandom % 100) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule